// File: doc/BRIEF.md
# Debug Mode and Event-Input Controller

This block owns a small debug-port configuration register and turns its fields into control lines for a processor's debug and trace logic. Software writes the register through a simple write strobe and reads it back at any time. Two fields, debug enable and halt-on-reset, are write-protected: they accept new values only while the system reset input is high. The trace fields and the event-control field can be written at any time. A module reset clears every field to zero.

A halt state machine watches system reset. Its states are `HS_IN_RESET` (system reset high), `HS_HALTED` and `HS_RUNNING`. The transitions are: any state goes to `HS_IN_RESET` while system reset is high. On release, `HS_IN_RESET` goes to `HS_HALTED` if debug enable and halt-on-reset are both set, and to `HS_RUNNING` otherwise. `HS_HALTED` and `HS_RUNNING` hold until the next system reset. The halt request is high exactly in `HS_HALTED`.

An asynchronous event pin passes through a two-stage synchronizer. With event-control set to breakpoint mode, the synchronized level drives the breakpoint request directly. In every other encoding, including the two reserved ones, a rising edge on the pin arms a one-shot sync flag for each enabled trace stream. Each stream has its own lane state machine with states `LS_IDLE` and `LS_PENDING`. The transitions are `LS_IDLE` to `LS_PENDING` on a qualified edge, and `LS_PENDING` to `LS_IDLE` on the trace unit's acknowledge.

Top module: `dbgc_ctrl`

## Requirements
- R1: After module reset, every register field reads as zero and every control output is low.
- R2: Register bit 0 (debug enable) and bit 1 (halt-on-reset) change on a write only while `sys_rst` is high. Writes made outside system reset leave both bits unchanged, and the other fields of the same write still take effect.
- R3: The trace field in bits 4:2 is writable at any time, and its bits drive independent enables: bit 4 enables branch (program) trace, bit 3 enables data trace and bit 2 enables ownership trace. All eight combinations are legal.
- R4: `dbg_enable` always equals register bit 0.
- R5: When `sys_rst` falls with bits 0 and 1 both set, `halt_req` is high from the next clock edge and stays high until `sys_rst` is seen high again. It is low one edge after that.
- R6: If either bit 0 or bit 1 is clear when system reset is released, `halt_req` stays low.
- R7: With event-control (bits 6:5) at 01, `brk_req` follows the level of `evt_pin` two clock edges later, for as long as the pin is held.
- R8: With event-control at 00, a rising edge on `evt_pin` sets `prog_sync_pend` if bit 4 is set and sets `data_sync_pend` if bit 3 is set. A flag is set on the third clock edge after the pin rises. A pin that stays high does not set a flag again.
- R9: A pending flag clears on the edge where its acknowledge is high. If a new edge arrives in the same cycle as the acknowledge, the flag is set.
- R10: Event-control codes 10 and 11 behave exactly like 00: the pin arms the sync flags and never raises `brk_req`.
- R11: `cfg_rdata` always returns the current 7-bit register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low module reset, clears the register and all state |
| sys_rst | input | 1 | System reset level, synchronous to clk, unlocks the protected bits |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 7 | Register write data |
| cfg_rdata | output | 7 | Current register value |
| evt_pin | input | 1 | Asynchronous event input |
| prog_sync_ack | input | 1 | Program trace sync message has been sent |
| data_sync_ack | input | 1 | Data trace sync message has been sent |
| dbg_enable | output | 1 | Debug mode enabled |
| halt_req | output | 1 | Halt request to the core after reset release |
| trace_branch_en | output | 1 | Branch trace enable |
| trace_data_en | output | 1 | Data trace enable |
| trace_own_en | output | 1 | Ownership trace enable |
| prog_sync_pend | output | 1 | Next program trace message must be a sync message |
| data_sync_pend | output | 1 | Next data trace message must be a sync message |
| brk_req | output | 1 | Breakpoint request, level-held |

## Verification
A corrupted register bit shows on `cfg_rdata` and on the matching enable output in the cycle after the write. This makes protection faults visible right away. A wrong halt state shows on `halt_req` one edge after `sys_rst` falls. A lane state machine stuck in `LS_PENDING`, or one that retriggers on a held pin, shows on the pending flags on the third edge after the pin rises or on the edge after an acknowledge. A mode decoder that treats a reserved code as breakpoint mode raises `brk_req` two edges after the pin goes high.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;

    localparam int REG_W  = 7;
    localparam int B_EN   = 0;
    localparam int B_OOR  = 1;
    localparam int TM_LO  = 2;
    localparam int TM_HI  = 4;
    localparam int EC_LO  = 5;
    localparam int EC_HI  = 6;
    localparam int TM_W   = TM_HI - TM_LO + 1;
    localparam int EC_W   = EC_HI - EC_LO + 1;

    // packed so that en lands on bit 0 and ec on bits 6:5
    typedef struct packed {
        logic [EC_W-1:0] ec;
        logic [TM_W-1:0] tm;
        logic            oor;
        logic            en;
    } cfg_t;

    typedef enum logic {
        EVM_SYNC = 1'b0,
        EVM_BRK  = 1'b1
    } evt_mode_e;

    typedef enum logic [1:0] {
        HS_IN_RESET = 2'd0,
        HS_HALTED   = 2'd1,
        HS_RUNNING  = 2'd2
    } halt_state_e;

    typedef enum logic {
        LS_IDLE    = 1'b0,
        LS_PENDING = 1'b1
    } lane_state_e;

    // only 01 selects breakpoint; every other code falls back to sync
    function automatic evt_mode_e decode_ec(input logic [EC_W-1:0] ec);
        return (ec == 2'b01) ? EVM_BRK : EVM_SYNC;
    endfunction

endpackage

// File: rtl/dbgc_cfg_reg.sv
module dbgc_cfg_reg
    import dbgc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output cfg_t             cfg_o
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.tm <= wr_data[TM_HI:TM_LO];
            cfg_q.ec <= wr_data[EC_HI:EC_LO];
            if (sys_rst) begin
                cfg_q.en  <= wr_data[B_EN];
                cfg_q.oor <= wr_data[B_OOR];
            end
        end
    end

    assign cfg_o = cfg_q;

    // R2: protected bits hold when written outside system reset
    a_r2_protect_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sys_rst) |=> ($stable(cfg_q.en) && $stable(cfg_q.oor)));

    // R3: writable field follows the write data
    a_r3_trace_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q.tm == $past(wr_data[TM_HI:TM_LO])));

endmodule

// File: rtl/dbgc_evt_sync.sv
module dbgc_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~last_q;

    // R8: an edge pulse lasts one cycle only
    a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/dbgc_halt_fsm.sv
module dbgc_halt_fsm
    import dbgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sys_rst,
    input  logic dbg_en,
    input  logic oor,
    output logic halt_req
);

    halt_state_e state_q, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IN_RESET;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        if (sys_rst) begin
            state_nx = HS_IN_RESET;
        end else begin
            unique case (state_q)
                HS_IN_RESET: state_nx = (dbg_en && oor) ? HS_HALTED : HS_RUNNING;
                HS_HALTED:   state_nx = HS_HALTED;
                HS_RUNNING:  state_nx = HS_RUNNING;
                default:     state_nx = HS_IN_RESET;
            endcase
        end
    end

    always_comb begin
        halt_req = (state_q == HS_HALTED);
    end

    // R5: release with both bits set leads to a halt request
    a_r5_halt_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_IN_RESET && !sys_rst && dbg_en && oor) |=> halt_req);

    // R5: system reset removes the request one edge later
    a_r5_halt_drops: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !halt_req);

    // R6: no halt without both configuration bits
    a_r6_halt_needs_bits: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (dbg_en && oor));

endmodule

// File: rtl/dbgc_sync_lanes.sv
module dbgc_sync_lanes
    import dbgc_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] set_i,
    input  logic [LANES-1:0] ack_i,
    output logic [LANES-1:0] pend_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_state_e st_q, st_nx;

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= LS_IDLE;
            else        st_q <= st_nx;
        end

        always_comb begin
            st_nx = st_q;
            unique case (st_q)
                LS_IDLE:    if (set_i[g]) st_nx = LS_PENDING;
                LS_PENDING: if (ack_i[g] && !set_i[g]) st_nx = LS_IDLE;
                default:    st_nx = LS_IDLE;
            endcase
        end

        always_comb begin
            pend_o[g] = (st_q == LS_PENDING);
        end

        // R8: a flag only rises when a qualified edge was seen
        a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_o[g] && !set_i[g]) |=> !pend_o[g]);

        // R9: acknowledge without a new edge clears the flag
        a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[g] && ack_i[g] && !set_i[g]) |=> !pend_o[g]);

        // R9: a new edge always leaves the flag set
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_o[g]);
    end

endmodule

// File: rtl/dbgc_ctrl.sv
module dbgc_ctrl
    import dbgc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rst,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             evt_pin,
    input  logic             prog_sync_ack,
    input  logic             data_sync_ack,
    output logic             dbg_enable,
    output logic             halt_req,
    output logic             trace_branch_en,
    output logic             trace_data_en,
    output logic             trace_own_en,
    output logic             prog_sync_pend,
    output logic             data_sync_pend,
    output logic             brk_req
);

    localparam int LANE_PROG = 0;
    localparam int LANE_DATA = 1;
    localparam int N_LANES   = 2;

    cfg_t              cfg;
    evt_mode_e         evt_mode;
    logic              evt_level;
    logic              evt_rise;
    logic [N_LANES-1:0] lane_set;
    logic [N_LANES-1:0] lane_ack;
    logic [N_LANES-1:0] lane_pend;

    dbgc_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sys_rst (sys_rst),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .cfg_o   (cfg)
    );

    dbgc_halt_fsm u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_rst  (sys_rst),
        .dbg_en   (cfg.en),
        .oor      (cfg.oor),
        .halt_req (halt_req)
    );

    dbgc_evt_sync #(.STAGES(SYNC_STAGES)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (evt_pin),
        .level_o (evt_level),
        .rise_o  (evt_rise)
    );

    assign evt_mode = decode_ec(cfg.ec);

    always_comb begin
        lane_set[LANE_PROG] = (evt_mode == EVM_SYNC) && evt_rise && cfg.tm[2];
        lane_set[LANE_DATA] = (evt_mode == EVM_SYNC) && evt_rise && cfg.tm[1];
        lane_ack[LANE_PROG] = prog_sync_ack;
        lane_ack[LANE_DATA] = data_sync_ack;
    end

    dbgc_sync_lanes #(.LANES(N_LANES)) u_lanes (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (lane_set),
        .ack_i  (lane_ack),
        .pend_o (lane_pend)
    );

    assign cfg_rdata       = cfg;
    assign dbg_enable      = cfg.en;
    assign trace_branch_en = cfg.tm[2];
    assign trace_data_en   = cfg.tm[1];
    assign trace_own_en    = cfg.tm[0];
    assign prog_sync_pend  = lane_pend[LANE_PROG];
    assign data_sync_pend  = lane_pend[LANE_DATA];
    assign brk_req         = (evt_mode == EVM_BRK) && evt_level;

    // R7: breakpoint only in breakpoint mode
    a_r7_brk_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (cfg_rdata[EC_HI:EC_LO] == 2'b01));

    // R10: reserved codes never raise a breakpoint
    a_r10_reserved_no_brk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[EC_HI] |-> !brk_req);

    // R8: program flag rises only with branch trace enabled
    a_r8_prog_needs_trace: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_sync_pend) |-> $past(trace_branch_en));

    // R8: data flag rises only with data trace enabled
    a_r8_data_needs_trace: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_sync_pend) |-> $past(trace_data_en));

endmodule

// File: tb/test_dbgc_ctrl.sv
`timescale 1ns/1ps
module test_dbgc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sys_rst;
    logic       cfg_wr;
    logic [6:0] cfg_wdata;
    logic [6:0] cfg_rdata;
    logic       evt_pin;
    logic       prog_sync_ack;
    logic       data_sync_ack;
    logic       dbg_enable;
    logic       halt_req;
    logic       trace_branch_en;
    logic       trace_data_en;
    logic       trace_own_en;
    logic       prog_sync_pend;
    logic       data_sync_pend;
    logic       brk_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dbgc_ctrl i_dbgc_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .sys_rst         (sys_rst),
        .cfg_wr          (cfg_wr),
        .cfg_wdata       (cfg_wdata),
        .cfg_rdata       (cfg_rdata),
        .evt_pin         (evt_pin),
        .prog_sync_ack   (prog_sync_ack),
        .data_sync_ack   (data_sync_ack),
        .dbg_enable      (dbg_enable),
        .halt_req        (halt_req),
        .trace_branch_en (trace_branch_en),
        .trace_data_en   (trace_data_en),
        .trace_own_en    (trace_own_en),
        .prog_sync_pend  (prog_sync_pend),
        .data_sync_pend  (data_sync_pend),
        .brk_req         (brk_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] v);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    function automatic logic [7:0] outs();
        return {1'b0, halt_req, trace_branch_en, trace_data_en, trace_own_en,
                prog_sync_pend, data_sync_pend, brk_req};
    endfunction

    task automatic t_reset();
        chk("R1 rdata", {1'b0, cfg_rdata}, 8'h00);
        chk("R1 outputs", outs(), 8'h00);
        chk("R1 dbg_enable", {7'b0, dbg_enable}, 8'h00);
    endtask

    task automatic t_protect_halt();
        wr(7'h03);
        chk("R2 write in reset", {1'b0, cfg_rdata}, 8'h03);
        chk("R4 dbg_enable", {7'b0, dbg_enable}, 8'h01);
        chk("R5 no halt in reset", {7'b0, halt_req}, 8'h00);
        @(negedge clk) sys_rst = 1'b0;
        @(negedge clk);
        chk("R5 halt after release", {7'b0, halt_req}, 8'h01);
        wr(7'h00);
        chk("R2 protected ignored", {1'b0, cfg_rdata}, 8'h03);
        repeat (3) @(negedge clk);
        chk("R5 halt held", {7'b0, halt_req}, 8'h01);
        sys_rst = 1'b1;
        @(negedge clk);
        chk("R5 halt drops", {7'b0, halt_req}, 8'h00);
        wr(7'h01);
        chk("R2 clear in reset", {1'b0, cfg_rdata}, 8'h01);
        @(negedge clk) sys_rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 enable only no halt", {7'b0, halt_req}, 8'h00);
        chk("R4 dbg_enable set", {7'b0, dbg_enable}, 8'h01);
        sys_rst = 1'b1;
        wr(7'h02);
        @(negedge clk) sys_rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 oor only no halt", {7'b0, halt_req}, 8'h00);
        chk("R4 dbg_enable clear", {7'b0, dbg_enable}, 8'h00);
    endtask

    task automatic t_trace_combos();
        for (int t = 0; t < 8; t++) begin
            wr(7'(t << 2));
            chk("R3 rdata", {1'b0, cfg_rdata}, 8'(8'h02 | (t << 2)));
            chk("R3 enables", {5'b0, trace_branch_en, trace_data_en, trace_own_en}, 8'(t));
        end
    endtask

    task automatic t_breakpoint();
        wr(7'h20);
        @(negedge clk) evt_pin = 1'b1;
        @(negedge clk);
        chk("R7 one edge", {7'b0, brk_req}, 8'h00);
        @(negedge clk);
        chk("R7 two edges", {7'b0, brk_req}, 8'h01);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 held", {7'b0, brk_req}, 8'h01);
        end
        chk("R7 no sync flags", {6'b0, prog_sync_pend, data_sync_pend}, 8'h00);
        evt_pin = 1'b0;
        @(negedge clk);
        chk("R7 still high", {7'b0, brk_req}, 8'h01);
        @(negedge clk);
        chk("R7 dropped", {7'b0, brk_req}, 8'h00);
    endtask

    task automatic t_sync_both();
        wr(7'h1C);
        repeat (2) @(negedge clk);
        evt_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 not yet", {6'b0, prog_sync_pend, data_sync_pend}, 8'h00);
        @(negedge clk);
        chk("R8 both set", {6'b0, prog_sync_pend, data_sync_pend}, 8'h03);
        chk("R8 no brk", {7'b0, brk_req}, 8'h00);
        prog_sync_ack = 1'b1;
        @(negedge clk);
        prog_sync_ack = 1'b0;
        chk("R9 prog cleared", {6'b0, prog_sync_pend, data_sync_pend}, 8'h01);
        data_sync_ack = 1'b1;
        @(negedge clk);
        data_sync_ack = 1'b0;
        chk("R9 data cleared", {6'b0, prog_sync_pend, data_sync_pend}, 8'h00);
        repeat (3) @(negedge clk);
        chk("R8 held pin no retrigger", {6'b0, prog_sync_pend, data_sync_pend}, 8'h00);
        evt_pin = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_sync_data_only();
        wr(7'h08);
        @(negedge clk) evt_pin = 1'b1;
        @(negedge clk) evt_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 data only", {6'b0, prog_sync_pend, data_sync_pend}, 8'h01);
        data_sync_ack = 1'b1;
        @(negedge clk) data_sync_ack = 1'b0;
        chk("R9 data ack", {6'b0, prog_sync_pend, data_sync_pend}, 8'h00);
    endtask

    task automatic t_set_wins();
        wr(7'h1C);
        prog_sync_ack = 1'b1;
        data_sync_ack = 1'b1;
        @(negedge clk) evt_pin = 1'b1;
        @(negedge clk) evt_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 set beats ack", {6'b0, prog_sync_pend, data_sync_pend}, 8'h03);
        @(negedge clk);
        chk("R9 ack after set", {6'b0, prog_sync_pend, data_sync_pend}, 8'h00);
        prog_sync_ack = 1'b0;
        data_sync_ack = 1'b0;
    endtask

    task automatic t_reserved(input logic [6:0] v);
        wr(v);
        @(negedge clk) evt_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 no brk", {7'b0, brk_req}, 8'h00);
        @(negedge clk);
        chk("R10 sync like default", {6'b0, prog_sync_pend, data_sync_pend}, 8'h03);
        chk("R10 no brk held", {7'b0, brk_req}, 8'h00);
        evt_pin = 1'b0;
        prog_sync_ack = 1'b1;
        data_sync_ack = 1'b1;
        @(negedge clk);
        prog_sync_ack = 1'b0;
        data_sync_ack = 1'b0;
        chk("R10 cleared", {6'b0, prog_sync_pend, data_sync_pend}, 8'h00);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_readback();
        wr(7'h7F);
        chk("R11 readback", {1'b0, cfg_rdata}, 8'h7E);
        wr(7'h35);
        chk("R11 readback2", {1'b0, cfg_rdata}, 8'h36);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n         = 1'b0;
        sys_rst       = 1'b1;
        cfg_wr        = 1'b0;
        cfg_wdata     = '0;
        evt_pin       = 1'b0;
        prog_sync_ack = 1'b0;
        data_sync_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_protect_halt();
        t_trace_combos();
        t_breakpoint();
        t_sync_both();
        t_sync_data_only();
        t_set_wins();
        t_reserved(7'h5C);
        t_reserved(7'h7C);
        t_readback();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule